// File: doc/BRIEF.md
# Auto-Incrementing Register Port with FIFO Window

This block is a byte-wide register port for a peripheral that holds an internal byte FIFO. The host sends a stream of commands. A set-address command loads an internal address pointer. Each read or write command then accesses the register under that pointer. After an access the pointer moves up by one, unless it sits on the FIFO data address. There the pointer holds still, so a burst of reads or writes streams bytes out of or into the FIFO.

A second pair of streams connects the FIFO to the peripheral's datapath. The datapath pops the bytes that the host wrote and pushes bytes for the host to read. A read-only length register reports the low eight bits of the byte count. A control register carries the upper count bits, the depth-mode bit, the sticky error flags and a flush bit.

Back-pressure rules:
- A command is taken when `cmd_valid` and `cmd_ready` are both high.
- `cmd_ready` falls while a read response is pending and `rsp_ready` is low. A response stays valid and stable until `rsp_ready` takes it.
- A datapath push is taken on `dp_push_valid && dp_push_ready`.
- A datapath pop is taken on `dp_pop_valid && dp_pop_ready`.
- A host FIFO access always takes priority over the datapath in the same direction.

Top module: `burst_regport`

## Requirements
- R1: After reset the byte count is 0, both error flags are 0, the depth mode is normal, no response is pending, `dp_pop_valid` is 0 and `dp_push_ready` is 1.
- R2: A set-address command (cmd_op 0) loads the pointer without advancing it. A read (cmd_op 2) or write (cmd_op 1) at any address other than 05h advances the 8-bit pointer by one afterwards. Reads of addresses other than 04h, 05h and 06h return 00h, and writes to them are ignored.
- R3: At address 05h the pointer stays put. A write there pushes the byte and a read there pops the oldest byte, in first-in first-out order.
- R4: Address 04h reads count bits 7:0. Address 06h reads as follows: bits 7:6 are count bits 9:8, bit 3 is underflow, bit 2 is overflow, bit 1 is the extended-depth mode, and bits 5:4 and 0 are 0.
- R5: A host write to 05h while the FIFO is full is dropped, leaves the count unchanged and sets the sticky overflow flag. Writing 06h with bit 2 set clears that flag without flushing the FIFO.
- R6: A host read of 05h while the FIFO is empty returns 00h and sets the sticky underflow flag. Writing 06h with bit 3 set clears that flag.
- R7: The FIFO holds at most 255 bytes in normal mode and 512 bytes in extended mode. `dp_push_ready` is 0 while the FIFO is full.
- R8: Writing 06h with bit 0 set empties the FIFO, so the count reads 0 one cycle later.
- R9: Writing 06h with a bit 1 value that differs from the current mode switches the mode and flushes the FIFO.
- R10: When a push and a pop are taken in the same cycle, one from the host and one from the datapath, the count is unchanged.
- R11: A read response stays valid with stable data while `rsp_ready` is low, and `cmd_ready` stays low during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Host command valid |
| cmd_ready | output | 1 | Host command accepted |
| cmd_op | input | 2 | 0 set address, 1 write, 2 read |
| cmd_data | input | 8 | Address for set-address, data for write |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 8 | Read response byte |
| dp_push_valid | input | 1 | Datapath byte to push |
| dp_push_ready | output | 1 | FIFO accepts a datapath push |
| dp_push_data | input | 8 | Datapath push byte |
| dp_pop_valid | output | 1 | FIFO byte available to datapath |
| dp_pop_ready | input | 1 | Datapath takes the byte |
| dp_pop_data | output | 8 | Oldest FIFO byte |
| fifo_count | output | 10 | Current byte count |
| ovf_flag | output | 1 | Sticky overflow flag |
| udf_flag | output | 1 | Sticky underflow flag |
| ext_mode | output | 1 | Extended-depth mode active |

## Verification
A host access to the FIFO data address and a datapath transfer in the opposite direction can complete in the same cycle. The bench provokes this in two ways. First, it issues a host write at 05h while holding `dp_pop_ready` high. Second, it issues a host read at 05h while driving `dp_push_valid`. In both cases it judges that the count is unchanged one cycle later, and that the bytes seen by each side come out in the order they were pushed.

// File: rtl/burst_regport_pkg.sv
package burst_regport_pkg;
  typedef enum logic [1:0] {
    OP_SETADDR = 2'd0,
    OP_WRITE   = 2'd1,
    OP_READ    = 2'd2
  } host_op_e;

  localparam logic [7:0] ADDR_LEN  = 8'h04;
  localparam logic [7:0] ADDR_DATA = 8'h05;
  localparam logic [7:0] ADDR_CTRL = 8'h06;

  localparam int CTL_FLUSH = 0;
  localparam int CTL_EXT   = 1;
  localparam int CTL_OVF   = 2;
  localparam int CTL_UDF   = 3;
endpackage

// File: rtl/rp_addr_ptr.sv
module rp_addr_ptr #(
  parameter int AW = 8,
  parameter logic [AW-1:0] HOLD_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          step,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        ptr <= '0;
    else if (load)                     ptr <= load_addr;
    else if (step && ptr != HOLD_ADDR) ptr <= ptr + AW'(1);
  end

  // R3
  hold_at_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && ptr == HOLD_ADDR) |=> ptr == $past(ptr));

  // R2
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && ptr != HOLD_ADDR) |=> ptr == $past(ptr) + AW'(1));
endmodule

// File: rtl/rp_fifo_core.sv
module rp_fifo_core #(
  parameter int DW        = 8,
  parameter int STD_DEPTH = 255,
  parameter int EXT_DEPTH = 512,
  localparam int CNT_W = $clog2(EXT_DEPTH + 1),
  localparam int PTR_W = $clog2(EXT_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             ext,
  input  logic             push_req,
  input  logic [DW-1:0]    push_data,
  input  logic             pop_req,
  output logic [DW-1:0]    pop_data,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [DW-1:0]    mem [EXT_DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] limit;
  logic             push_ok, pop_ok;

  assign limit    = ext ? CNT_W'(EXT_DEPTH) : CNT_W'(STD_DEPTH);
  assign full     = count >= limit;
  assign empty    = count == '0;
  assign push_ok  = push_req && !full && !flush;
  assign pop_ok   = pop_req && !empty && !flush;
  assign pop_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + PTR_W'(1);
      if (pop_ok)  rd_ptr <= rd_ptr + PTR_W'(1);
      count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  // R7
  depth_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(EXT_DEPTH));

  // R10
  push_pop_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req && !full && !empty && !flush) |=> $stable(count));

  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0);
endmodule

// File: rtl/burst_regport.sv
module burst_regport #(
  parameter int STD_DEPTH = 255,
  parameter int EXT_DEPTH = 512,
  localparam int DW    = 8,
  localparam int CNT_W = $clog2(EXT_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [DW-1:0]    cmd_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [DW-1:0]    rsp_data,
  input  logic             dp_push_valid,
  output logic             dp_push_ready,
  input  logic [DW-1:0]    dp_push_data,
  output logic             dp_pop_valid,
  input  logic             dp_pop_ready,
  output logic [DW-1:0]    dp_pop_data,
  output logic [CNT_W-1:0] fifo_count,
  output logic             ovf_flag,
  output logic             udf_flag,
  output logic             ext_mode
);
  import burst_regport_pkg::*;

  host_op_e         op;
  logic             acc, is_wr, is_rd, at_fifo, ctrl_wr;
  logic             host_push, host_pop, flush_now;
  logic             push_req, pop_req, full, empty;
  logic [DW-1:0]    push_data, head, rd_mux, ctrl_rd;
  logic [7:0]       ptr;
  logic [CNT_W-1:0] count;
  logic             ext_q, ovf_q, udf_q;

  assign op        = host_op_e'(cmd_op);
  assign cmd_ready = !rsp_valid || rsp_ready;
  assign acc       = cmd_valid && cmd_ready;
  assign is_wr     = acc && op == OP_WRITE;
  assign is_rd     = acc && op == OP_READ;
  assign at_fifo   = ptr == ADDR_DATA;
  assign host_push = is_wr && at_fifo;
  assign host_pop  = is_rd && at_fifo;
  assign ctrl_wr   = is_wr && ptr == ADDR_CTRL;
  assign flush_now = ctrl_wr && (cmd_data[CTL_FLUSH] || cmd_data[CTL_EXT] != ext_q);

  assign dp_push_ready = !full && !host_push && !flush_now;
  assign dp_pop_valid  = !empty && !host_pop && !flush_now;
  assign dp_pop_data   = head;

  assign push_req  = host_push || (dp_push_valid && dp_push_ready);
  assign push_data = host_push ? cmd_data : dp_push_data;
  assign pop_req   = host_pop || (dp_pop_valid && dp_pop_ready);

  rp_addr_ptr #(.AW(8), .HOLD_ADDR(ADDR_DATA)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (acc && op == OP_SETADDR),
    .load_addr (cmd_data),
    .step      (is_wr || is_rd),
    .ptr       (ptr)
  );

  rp_fifo_core #(.DW(DW), .STD_DEPTH(STD_DEPTH), .EXT_DEPTH(EXT_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush_now),
    .ext       (ext_q),
    .push_req  (push_req),
    .push_data (push_data),
    .pop_req   (pop_req),
    .pop_data  (head),
    .count     (count),
    .full      (full),
    .empty     (empty)
  );

  always_comb begin
    ctrl_rd            = '0;
    ctrl_rd[7:6]       = 2'(count >> 8);
    ctrl_rd[CTL_UDF]   = udf_q;
    ctrl_rd[CTL_OVF]   = ovf_q;
    ctrl_rd[CTL_EXT]   = ext_q;
    case (ptr)
      ADDR_LEN:  rd_mux = count[7:0];
      ADDR_DATA: rd_mux = empty ? '0 : head;
      ADDR_CTRL: rd_mux = ctrl_rd;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= 1'b0;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      if (ctrl_wr) ext_q <= cmd_data[CTL_EXT];
      ovf_q <= (ovf_q && !(ctrl_wr && cmd_data[CTL_OVF])) || (host_push && full);
      udf_q <= (udf_q && !(ctrl_wr && cmd_data[CTL_UDF])) || (host_pop && empty);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (is_rd) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign fifo_count = count;
  assign ovf_flag   = ovf_q;
  assign udf_flag   = udf_q;
  assign ext_mode   = ext_q;

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data));

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ctrl_wr) |=> ovf_flag);

  // R6
  udf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (udf_flag && !ctrl_wr) |=> udf_flag);

  // R7
  no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !dp_push_ready);
endmodule

// File: tb/sim_burst_regport.sv
module sim_burst_regport;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0, rsp_ready = 1'b1;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_data = 8'h00, dp_push_data = 8'h00;
  logic       dp_push_valid = 1'b0, dp_pop_ready = 1'b0;
  logic       cmd_ready, rsp_valid, dp_push_ready, dp_pop_valid;
  logic [7:0] rsp_data, dp_pop_data;
  logic [9:0] fifo_count;
  logic       ovf_flag, udf_flag, ext_mode;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;
  logic [7:0] rd;

  always #10 clk = ~clk;

  burst_regport u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .dp_push_valid(dp_push_valid),
    .dp_push_ready(dp_push_ready), .dp_push_data(dp_push_data),
    .dp_pop_valid(dp_pop_valid), .dp_pop_ready(dp_pop_ready),
    .dp_pop_data(dp_pop_data), .fifo_count(fifo_count), .ovf_flag(ovf_flag),
    .udf_flag(udf_flag), .ext_mode(ext_mode)
  );

  localparam logic [1:0] SA = 2'd0, WR = 2'd1, RD = 2'd2;
  // {op, data, check, expected}
  localparam logic [18:0] VEC [16] = '{
    {SA, 8'h05, 1'b0, 8'h00}, {WR, 8'hA1, 1'b0, 8'h00},
    {WR, 8'hB2, 1'b0, 8'h00}, {WR, 8'hC3, 1'b0, 8'h00},
    {SA, 8'h04, 1'b0, 8'h00}, {RD, 8'h00, 1'b1, 8'h03},
    {RD, 8'h00, 1'b1, 8'hA1}, {RD, 8'h00, 1'b1, 8'hB2},
    {RD, 8'h00, 1'b1, 8'hC3}, {RD, 8'h00, 1'b1, 8'h00},
    {SA, 8'h06, 1'b0, 8'h00}, {RD, 8'h00, 1'b1, 8'h08},
    {RD, 8'h00, 1'b1, 8'h00}, {SA, 8'h06, 1'b0, 8'h00},
    {WR, 8'h08, 1'b0, 8'h00}, {RD, 8'h00, 1'b1, 8'h00}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic host(input logic [1:0] op, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic host_rd(output logic [7:0] d);
    host(RD, 8'h00);
    @(negedge clk);
    d = rsp_data;
  endtask

  task automatic dp_fill(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dp_push_valid = 1'b1; dp_push_data = 8'(base + i);
      @(posedge clk); #1;
    end
    dp_push_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(fifo_count == 0 && !ovf_flag && !udf_flag && !ext_mode, "R1 count/flags", int'(fifo_count), 0);
    check(!rsp_valid && !dp_pop_valid && dp_push_ready, "R1 stream pins",
          int'({rsp_valid, dp_pop_valid, dp_push_ready}), 1);

    // vector table: R2 R3 R4 R6
    for (int k = 0; k < 16; k++) begin
      if (VEC[k][18:17] == RD) begin
        host_rd(rd);
        if (VEC[k][8])
          check(rd == VEC[k][7:0] && rsp_valid, $sformatf("R3 R4 R6 R2 table step %0d", k),
                int'(rd), int'(VEC[k][7:0]));
      end else begin
        host(VEC[k][18:17], VEC[k][16:9]);
      end
    end
    check(!udf_flag, "R6 underflow cleared", int'(udf_flag), 0);

    // R11 back-pressure on response
    rsp_ready = 1'b0;
    host(SA, 8'h06);
    host(RD, 8'h00);
    @(negedge clk);
    rd = rsp_data;
    check(rsp_valid && !cmd_ready, "R11 held, cmd stalled", int'({rsp_valid, cmd_ready}), 2);
    @(negedge clk);
    check(rsp_valid && rsp_data == rd, "R11 stable data", int'(rsp_data), int'(rd));
    rsp_ready = 1'b1;
    @(negedge clk);
    check(!rsp_valid && cmd_ready, "R11 released", int'({rsp_valid, cmd_ready}), 1);

    // R7 normal depth, R5 overflow
    dp_fill(255, 0);
    @(negedge clk);
    check(fifo_count == 255 && !dp_push_ready, "R7 normal full", int'(fifo_count), 255);
    host(SA, 8'h05);
    host(WR, 8'h55);
    @(negedge clk);
    check(ovf_flag && fifo_count == 255, "R5 dropped write", int'(fifo_count), 255);
    host(SA, 8'h04);
    host_rd(rd);
    check(rd == 8'hFF, "R4 length 255", int'(rd), 255);
    host_rd(rd);
    check(rd == 8'h00 && fifo_count == 254, "R3 first popped", int'(rd), 0);

    // R10 host push + datapath pop
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = WR; cmd_data = 8'h77; dp_pop_ready = 1'b1;
    #1;
    check(dp_pop_valid && dp_pop_data == 8'h01, "R10 dp pop head", int'(dp_pop_data), 1);
    @(posedge clk); #1;
    cmd_valid = 1'b0; dp_pop_ready = 1'b0;
    @(negedge clk);
    check(fifo_count == 254, "R10 push+pop count", int'(fifo_count), 254);

    // R10 host pop + datapath push
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = RD; dp_push_valid = 1'b1; dp_push_data = 8'hEE;
    #1;
    check(dp_push_ready, "R10 dp push ready", int'(dp_push_ready), 1);
    @(posedge clk); #1;
    cmd_valid = 1'b0; dp_push_valid = 1'b0;
    @(negedge clk);
    check(rsp_data == 8'h02 && fifo_count == 254, "R10 pop+push", int'(rsp_data), 2);

    // R5 clear overflow without flush
    host(SA, 8'h06);
    host(WR, 8'h04);
    @(negedge clk);
    check(!ovf_flag && fifo_count == 254, "R5 ovf clear keeps data", int'(fifo_count), 254);

    // R9 mode change flushes
    host(SA, 8'h06);
    host(WR, 8'h02);
    @(negedge clk);
    check(fifo_count == 0 && ext_mode, "R9 mode flush", int'(fifo_count), 0);

    // R4 upper bits, R2 increment past reserved
    dp_fill(300, 0);
    host(SA, 8'h06);
    host_rd(rd);
    check(rd == 8'h42, "R4 control with count 300", int'(rd), 8'h42);
    host(SA, 8'h03);
    host_rd(rd);
    check(rd == 8'h00, "R2 reserved reads zero", int'(rd), 0);
    host_rd(rd);
    check(rd == 8'h2C, "R2 advanced to length", int'(rd), 8'h2C);

    // R7 extended depth
    dp_fill(212, 44);
    @(negedge clk);
    check(fifo_count == 512 && !dp_push_ready, "R7 extended full", int'(fifo_count), 512);
    host(SA, 8'h06);
    host_rd(rd);
    check(rd == 8'h82, "R4 control with count 512", int'(rd), 8'h82);

    // R8 flush bit, mode kept
    host(SA, 8'h06);
    host(WR, 8'h03);
    @(negedge clk);
    check(fifo_count == 0 && ext_mode, "R8 flush", int'(fifo_count), 0);
    host(SA, 8'h06);
    host_rd(rd);
    check(rd == 8'h02, "R8 control after flush", int'(rd), 2);

    // R3 datapath drains host writes in order
    host(SA, 8'h05);
    host(WR, 8'h11);
    host(WR, 8'h22);
    @(negedge clk);
    check(dp_pop_valid && dp_pop_data == 8'h11, "R3 order first", int'(dp_pop_data), 8'h11);
    dp_pop_ready = 1'b1;
    @(posedge clk); #1;
    dp_pop_ready = 1'b0;
    @(negedge clk);
    check(dp_pop_data == 8'h22 && fifo_count == 1, "R3 order second", int'(dp_pop_data), 8'h22);

    finish_run();
  end
endmodule